// File: doc/BRIEF.md
# Sleep-Aware Watchdog Countdown

This block is a 12-bit watchdog that counts down once per clock while enabled and expects software to kick it before it runs out. A single control word, written through a write strobe, enables the watchdog, picks how it behaves in the low-power states, decides whether running out requests a system reset, and supplies the value the counter restarts from.

Three power-state indications (light sleep, deep sleep level 1, deep sleep level 2) gate the counting. A 2-bit halt selector in the control word picks which of the two lighter states freeze the counter. The deepest state always freezes it. A frozen count is kept exactly and counting picks up from it when the state ends. When the counter passes zero it reloads and raises a sticky underflow flag. It also gives a one-cycle reset request when the reset enable is set, and a one-cycle wake request when a sleep state is active.

Top module: `wdt_sleep_halt`

## Requirements
- R1: After reset the control readback is 0x0000_0FFF, the count is 0xFFF, and the underflow flag, wake request and reset request are all 0.
- R2: A control write stores only bit 16 (enable), bits 15:14 (halt selector), bit 13 (reset enable) and bits 11:0 (reload). The readback equals the written data ANDed with 0x0001_EFFF.
- R3: While the enable bit is 0, the count stays at 0xFFF, and a kick has no effect.
- R4: A write that sets the enable bit while it was 0 makes the count equal to the written reload value after that clock edge. From then on, each clock edge decrements the count by one.
- R5: Halt selector 00 counts during light sleep and deep sleep 1. Selector 01 counts during light sleep and freezes during deep sleep 1. Selectors 10 and 11 freeze during both.
- R6: While the deep sleep 2 indication is high, the count does not change, whatever the halt selector holds.
- R7: When a freezing state ends, counting resumes from the frozen value with no reload.
- R8: A kick while enabled makes the count equal to the reload field after that edge.
- R9: At an edge where the count is 0 and counting is allowed, the count becomes the reload value and the underflow flag sets. The flag stays set until the next control write clears it.
- R10: The reset request is high for the single cycle after an underflow edge, and only when the reset enable bit is 1.
- R11: The wake request is high for the single cycle after an underflow edge that happens while light sleep or deep sleep 1 is indicated.
- R12: A write that clears the enable bit returns the count to 0xFFF after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| kick | input | 1 | Reload strobe from software |
| pm_sleep | input | 1 | Light sleep indication |
| pm_deep1 | input | 1 | Deep sleep level 1 indication |
| pm_deep2 | input | 1 | Deep sleep level 2 indication |
| ctl_rdata | output | 32 | Stored control word |
| count | output | 12 | Current counter value |
| uf_flag | output | 1 | Sticky underflow flag |
| wake_req | output | 1 | Wake-up request pulse |
| rst_req | output | 1 | System reset request pulse |

## Verification
The hardest situation to produce from the ports is an underflow that lands exactly while a sleep state is active with the halt selector still letting the counter run. At the same time, the reset enable has to be set in one case and clear in another. The stimulus reaches it with very small reload values (3) so that zero arrives within a few cycles. It rewrites the control word while the watchdog is enabled to change the selector and reset enable without reloading, then raises the sleep indication on the cycle before the count reaches zero. The bench also walks every selector through both lighter sleep states and checks that the frozen count resumes without loss.

// File: rtl/wdt_sleep_halt.sv
module wdt_sleep_halt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  input  logic             kick,
  input  logic             pm_sleep,
  input  logic             pm_deep1,
  input  logic             pm_deep2,
  output logic [31:0]      ctl_rdata,
  output logic [CNT_W-1:0] count,
  output logic             uf_flag,
  output logic             wake_req,
  output logic             rst_req
);
  localparam int EN_B    = 16;
  localparam int SEL_B   = 14;
  localparam int RSTEN_B = 13;
  localparam logic [31:0] WMASK = 32'h0001_E000 | ((32'd1 << CNT_W) - 32'd1);
  localparam logic [CNT_W-1:0] CNT_DEF = '1;
  localparam logic [31:0] CTL_RST = {{(32-CNT_W){1'b0}}, CNT_DEF};

  logic [31:0]      ctl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       sel;
  logic             en, rsten, wr_en, halt, run, uf_ev;
  logic [CNT_W-1:0] rld;

  assign en    = ctl_q[EN_B];
  assign sel   = ctl_q[SEL_B +: 2];
  assign rsten = ctl_q[RSTEN_B];
  assign rld   = ctl_q[CNT_W-1:0];
  assign wr_en = cfg_wdata[EN_B];

  assign halt  = pm_deep2 | (pm_deep1 & (sel != 2'b00)) | (pm_sleep & sel[1]);
  assign run   = en & ~(cfg_we & ~wr_en) & ~kick & ~halt;
  assign uf_ev = run & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RST;
    else if (cfg_we) ctl_q <= cfg_wdata & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= CNT_DEF;
    else if (cfg_we && !wr_en)  cnt_q <= CNT_DEF;
    else if (!en)               cnt_q <= cfg_we ? cfg_wdata[CNT_W-1:0] : CNT_DEF;
    else if (kick)              cnt_q <= rld;
    else if (uf_ev)             cnt_q <= rld;
    else if (run)               cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uf_flag  <= 1'b0;
      wake_req <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      if (uf_ev)       uf_flag <= 1'b1;
      else if (cfg_we) uf_flag <= 1'b0;
      wake_req <= uf_ev & (pm_sleep | pm_deep1);
      rst_req  <= uf_ev & rsten;
    end
  end

  assign ctl_rdata = ctl_q;
  assign count     = cnt_q;
endmodule

// File: rtl/wdt_sleep_halt_chk.sv
module wdt_sleep_halt_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             kick,
  input logic             pm_sleep,
  input logic             pm_deep1,
  input logic             pm_deep2,
  input logic [31:0]      ctl_rdata,
  input logic [CNT_W-1:0] count,
  input logic             uf_flag,
  input logic             wake_req,
  input logic             rst_req
);
  // R3
  disabled_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[16] |-> count == '1);
  // R6
  deep2_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_deep2 && !cfg_we && !kick && ctl_rdata[16]) |=> $stable(count));
  // R9
  uf_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uf_flag) |-> $past(count) == '0);
  // R10
  rst_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(ctl_rdata[13]) && uf_flag));
  // R11
  wake_in_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> ($past(pm_sleep || pm_deep1) && uf_flag));
endmodule

bind wdt_sleep_halt wdt_sleep_halt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .kick(kick),
  .pm_sleep(pm_sleep), .pm_deep1(pm_deep1), .pm_deep2(pm_deep2),
  .ctl_rdata(ctl_rdata), .count(count), .uf_flag(uf_flag),
  .wake_req(wake_req), .rst_req(rst_req)
);

// File: tb/sim_wdt_sleep_halt.sv
`timescale 1ns/1ps
module sim_wdt_sleep_halt;
  logic clk = 0, rst_n = 0, cfg_we = 0, kick = 0;
  logic pm_sleep = 0, pm_deep1 = 0, pm_deep2 = 0;
  logic [31:0] cfg_wdata = '0, ctl_rdata;
  logic [11:0] count;
  logic uf_flag, wake_req, rst_req;

  always #2 clk = ~clk;

  wdt_sleep_halt u0 (.*);

  typedef struct { int kind; logic [31:0] exp; string req; } item_t;
  item_t sbq[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic expect_v(int kind, logic [31:0] v, string req);
    item_t it;
    it.kind = kind; it.exp = v; it.req = req;
    sbq.push_back(it);
  endtask

  always @(negedge clk) begin
    #1;
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      case (it.kind)
        0: act = {20'd0, count};
        1: act = {31'd0, uf_flag};
        2: act = {31'd0, wake_req};
        3: act = {31'd0, rst_req};
        default: act = ctl_rdata;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind%0d got %h exp %h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [31:0] d);
    cfg_we = 1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0; cfg_wdata = '0;
  endtask

  task automatic do_kick();
    kick = 1;
    @(negedge clk);
    kick = 0;
  endtask

  task automatic finish_run();
    #2;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog timeout got hang exp finish");
      finish_run();
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    expect_v(4, 32'h0000_0FFF, "R1"); expect_v(0, 12'hFFF, "R1");
    expect_v(1, 0, "R1"); expect_v(2, 0, "R1"); expect_v(3, 0, "R1");

    do_kick(); step(2);
    expect_v(0, 12'hFFF, "R3");

    wr(32'hFFFF_F005);
    expect_v(4, 32'h0001_E005, "R2"); expect_v(0, 12'h005, "R4");
    step(2); expect_v(0, 12'h003, "R4");
    wr(32'h0); expect_v(0, 12'hFFF, "R12"); expect_v(4, 0, "R2");

    wr(32'h0001_0100); expect_v(0, 12'h100, "R4");
    pm_sleep = 1; step(3); expect_v(0, 12'h0FD, "R5 sel00 sleep");
    pm_sleep = 0; pm_deep1 = 1; step(2); expect_v(0, 12'h0FB, "R5 sel00 deep1");
    pm_deep1 = 0;
    wr(32'h0001_4100); expect_v(0, 12'h0FA, "R5");
    pm_deep1 = 1; step(3); expect_v(0, 12'h0FA, "R5 sel01 deep1");
    pm_deep1 = 0; pm_sleep = 1; step(2); expect_v(0, 12'h0F8, "R5 sel01 sleep");
    pm_sleep = 0;
    wr(32'h0001_8100); expect_v(0, 12'h0F7, "R5");
    pm_sleep = 1; step(3); expect_v(0, 12'h0F7, "R5 sel10 sleep");
    pm_sleep = 0; pm_deep1 = 1; step(2); expect_v(0, 12'h0F7, "R5 sel10 deep1");
    pm_deep1 = 0; step(1); expect_v(0, 12'h0F6, "R7");
    wr(32'h0001_0100); expect_v(0, 12'h0F5, "R6");
    pm_deep2 = 1; step(4); expect_v(0, 12'h0F5, "R6");
    pm_deep2 = 0; step(2); expect_v(0, 12'h0F3, "R7");

    do_kick(); expect_v(0, 12'h100, "R8");
    step(1); expect_v(0, 12'h0FF, "R8");

    wr(32'h0); wr(32'h0001_0003);
    step(3); expect_v(0, 0, "R9"); expect_v(1, 0, "R9");
    step(1); expect_v(0, 3, "R9"); expect_v(1, 1, "R9");
    expect_v(3, 0, "R10"); expect_v(2, 0, "R11");
    step(1); expect_v(1, 1, "R9"); expect_v(0, 2, "R9");
    wr(32'h0001_0003); expect_v(1, 0, "R9"); expect_v(0, 1, "R9");

    wr(32'h0001_2003); expect_v(0, 0, "R10");
    pm_sleep = 1; step(1);
    expect_v(0, 3, "R9"); expect_v(3, 1, "R10"); expect_v(2, 1, "R11");
    step(1); expect_v(3, 0, "R10"); expect_v(2, 0, "R11"); expect_v(0, 2, "R5");
    pm_sleep = 0; pm_deep1 = 1; step(3);
    expect_v(2, 1, "R11"); expect_v(3, 1, "R10"); expect_v(0, 3, "R11");
    pm_deep1 = 0; step(1);

    done = 1;
    step(1);
    finish_run();
  end
endmodule